// File: doc/BRIEF.md
# Two-Phase Pipeline Stage Sequencer

This block paces a four-stage processor pipeline (fetch, decode, execute, memory-with-writeback) that is folded into two alternating phases. A one-bit phase toggles every clock while the core runs. Fetch and execute work in the even phase, and decode and memory work in the odd phase. Because of this, a new instruction can enter at most once every two clocks. A dependent instruction is therefore never one cycle behind its producer, so no forwarding paths are needed.

The same phase also controls the single memory port. Instruction fetch owns the port in even cycles and data access owns it in odd cycles, so the two never collide. The register file is strobed only in even cycles. A separate memory/writeback pipeline register is not needed because those two steps form one stage.

Every output is registered. Each output describes the clock period that follows the edge at which the run input and the request inputs were sampled.

Top module: `pipe_phase_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, all stage enables, the register-file strobe, the memory select, both grants and the error flag are 0, and the phase returns to even.
- R2: In an even running cycle, exactly the fetch bit (stage_en[0]) and the execute bit (stage_en[2]) are 1.
- R3: In an odd running cycle, exactly the decode bit (stage_en[1]) and the memory/writeback bit (stage_en[3]) are 1.
- R4: While run stays high, the phase alternates every cycle, so the fetch enable is never 1 in two consecutive cycles.
- R5: The first running cycle after reset is an even cycle, which is a fetch cycle.
- R6: A cycle with run low has all stage enables, the strobe and both grants at 0. The phase is frozen, so the next running cycle resumes the phase that would have come next.
- R7: mem_sel is 0 (program counter) in even running cycles and 1 (data address) in odd running cycles. It is 0 when the core is stalled.
- R8: fetch_gnt equals fetch_req in even running cycles and data_gnt equals data_req in odd running cycles. The two grants are never 1 together.
- R9: proto_err is 1 exactly for a running even cycle in which data_req was high. Such a request gets no grant.
- R10: rf_strobe is 1 in every even running cycle and in no other cycle.
- R11: A fetch_req in an odd running cycle is ignored: fetch_gnt stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Core runs; low freezes the phase |
| fetch_req | input | 1 | Instruction fetch wants the memory port |
| data_req | input | 1 | Load/store wants the memory port |
| stage_en | output | STAGE_CNT | Per-stage enables: [0] fetch, [1] decode, [2] execute, [3] memory/writeback |
| rf_strobe | output | 1 | Register-file read/write strobe |
| mem_sel | output | 1 | Memory address select: 0 program counter, 1 data address |
| fetch_gnt | output | 1 | Port granted to fetch |
| data_gnt | output | 1 | Port granted to data access |
| proto_err | output | 1 | Data request arrived in an even cycle |

## Verification
The hardest case to reach is a stall that begins in the middle of an odd phase, followed by a restart. That path checks both the frozen phase and the resumed order, and mostly random stimulus rarely stops the core at exactly that cycle. A directed sequence forces it: reset, one running cycle, then run low for several cycles with both requests high, then run high again. The bench expects the restart to land in the odd phase with data granted. Random traffic then mixes short stalls with even-phase data requests so that the error flag and odd-phase fetch requests get exercised.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;
  typedef enum logic {PH_EVEN = 1'b0, PH_ODD = 1'b1} phase_t;

  localparam int STAGES  = 4;
  localparam int STG_IF  = 0;
  localparam int STG_ID  = 1;
  localparam int STG_EX  = 2;
  localparam int STG_MEM = 3;

  // stages alternate: even index works in even phase
  function automatic phase_t stage_phase(input int idx);
    return ((idx % 2) == 0) ? PH_EVEN : PH_ODD;
  endfunction
endpackage

// File: rtl/phase_gen.sv
module phase_gen
  import phase_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   run_en,
  output phase_t phase_q
);
  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_EVEN;
    else if (run_en) phase_q <= (phase_q == PH_EVEN) ? PH_ODD : PH_EVEN;
  end

  // R6
  phase_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> $stable(phase_q));
endmodule

// File: rtl/stage_gate.sv
module stage_gate
  import phase_seq_pkg::*;
#(
  parameter int STAGE_CNT = STAGES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run_en,
  input  phase_t               phase,
  output logic [STAGE_CNT-1:0] stage_en,
  output logic                 rf_strobe
);
  logic [STAGE_CNT-1:0] en_nxt;

  for (genvar g = 0; g < STAGE_CNT; g++) begin : g_stage
    assign en_nxt[g] = run_en && (phase == stage_phase(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_en  <= '0;
      rf_strobe <= 1'b0;
    end else begin
      stage_en  <= en_nxt;
      rf_strobe <= run_en && (phase == PH_EVEN);
    end
  end

  // R2 / R3
  even_odd_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !((stage_en[STG_IF] || stage_en[STG_EX]) && (stage_en[STG_ID] || stage_en[STG_MEM])));
  // R4
  no_back_to_back_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    stage_en[STG_IF] && run_en |=> !stage_en[STG_IF]);
  // R6
  stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (stage_en == '0) && !rf_strobe);
endmodule

// File: rtl/mem_port_arb.sv
module mem_port_arb
  import phase_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   run_en,
  input  phase_t phase,
  input  logic   fetch_req,
  input  logic   data_req,
  output logic   mem_sel,
  output logic   fetch_gnt,
  output logic   data_gnt,
  output logic   proto_err
);
  logic even_run, odd_run;
  assign even_run = run_en && (phase == PH_EVEN);
  assign odd_run  = run_en && (phase == PH_ODD);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_sel   <= 1'b0;
      fetch_gnt <= 1'b0;
      data_gnt  <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      mem_sel   <= odd_run;
      fetch_gnt <= even_run && fetch_req;
      data_gnt  <= odd_run && data_req;
      proto_err <= even_run && data_req;
    end
  end

  // R8
  port_single_owner_chk: assert property (@(posedge clk) disable iff (rst)
    !(fetch_gnt && data_gnt));
  // R9
  err_needs_data_req_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> $past(data_req) && !data_gnt);
  // R7
  data_gnt_sel_chk: assert property (@(posedge clk) disable iff (rst)
    data_gnt |-> mem_sel);
endmodule

// File: rtl/pipe_phase_seq.sv
module pipe_phase_seq
  import phase_seq_pkg::*;
#(
  parameter int STAGE_CNT = STAGES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run_en,
  input  logic                 fetch_req,
  input  logic                 data_req,
  output logic [STAGE_CNT-1:0] stage_en,
  output logic                 rf_strobe,
  output logic                 mem_sel,
  output logic                 fetch_gnt,
  output logic                 data_gnt,
  output logic                 proto_err
);
  phase_t phase;

  phase_gen u_phase (
    .clk(clk), .rst(rst), .run_en(run_en), .phase_q(phase)
  );

  stage_gate #(.STAGE_CNT(STAGE_CNT)) u_gate (
    .clk(clk), .rst(rst), .run_en(run_en), .phase(phase),
    .stage_en(stage_en), .rf_strobe(rf_strobe)
  );

  mem_port_arb u_arb (
    .clk(clk), .rst(rst), .run_en(run_en), .phase(phase),
    .fetch_req(fetch_req), .data_req(data_req),
    .mem_sel(mem_sel), .fetch_gnt(fetch_gnt), .data_gnt(data_gnt),
    .proto_err(proto_err)
  );

  // R10
  rf_only_pc_phase_chk: assert property (@(posedge clk) disable iff (rst)
    rf_strobe |-> !mem_sel && stage_en[STG_EX]);
  // R11
  fetch_gnt_in_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_gnt |-> stage_en[STG_IF]);
endmodule

// File: tb/pipe_phase_seq_bench.sv
module pipe_phase_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 1'b0, rst = 1'b1, run_en = 1'b0, fetch_req = 1'b0, data_req = 1'b0;
  logic [N-1:0] stage_en;
  logic rf_strobe, mem_sel, fetch_gnt, data_gnt, proto_err;

  int checks = 0, fails = 0;
  logic m_ph = 1'b0;          // model phase, 0 even
  logic [N-1:0] e_en;
  logic e_rf, e_sel, e_fg, e_dg, e_err;
  string e_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_phase_seq u_pipe_phase_seq (
    .clk(clk), .rst(rst), .run_en(run_en), .fetch_req(fetch_req), .data_req(data_req),
    .stage_en(stage_en), .rf_strobe(rf_strobe), .mem_sel(mem_sel),
    .fetch_gnt(fetch_gnt), .data_gnt(data_gnt), .proto_err(proto_err)
  );

  function automatic logic [N-1:0] exp_en(input logic run, input logic ph);
    if (!run) return '0;
    return ph ? 4'b1010 : 4'b0101;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // drive at negedge, predict output after next posedge, check at the negedge after it
  task automatic step(input logic r, input logic f, input logic d);
    run_en = r; fetch_req = f; data_req = d;
    e_en  = exp_en(r, m_ph);
    e_rf  = r && !m_ph;
    e_sel = r && m_ph;
    e_fg  = r && !m_ph && f;
    e_dg  = r && m_ph && d;
    e_err = r && !m_ph && d;
    e_tag = !r ? "R6" : (m_ph ? "R3" : "R2");
    if (r) m_ph = ~m_ph;
    @(posedge clk); @(negedge clk);
    chk(e_tag, {4'b0, stage_en}, {4'b0, e_en});
    chk("R10", {7'b0, rf_strobe}, {7'b0, e_rf});
    chk("R7", {7'b0, mem_sel}, {7'b0, e_sel});
    chk((r && m_ph == 1'b0 && f) ? "R11" : "R8", {7'b0, fetch_gnt}, {7'b0, e_fg});
    chk("R8", {7'b0, data_gnt}, {7'b0, e_dg});
    chk("R9", {7'b0, proto_err}, {7'b0, e_err});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state with busy inputs
    rst = 1'b1; run_en = 1'b1; fetch_req = 1'b1; data_req = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", {4'b0, stage_en}, 8'h0);
    chk("R1", {4'b0, rf_strobe, mem_sel, fetch_gnt, data_gnt, proto_err}, 8'h0);
    rst = 1'b0; run_en = 1'b0; fetch_req = 1'b0; data_req = 1'b0;
    m_ph = 1'b0;
    // R5: first run cycle is even, fetch granted
    step(1'b1, 1'b1, 1'b0);
    chk("R5", {7'b0, stage_en[0]}, 8'h1);
    // R6: stall in odd phase with requests, then resume odd
    step(1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    chk("R6", {7'b0, stage_en[3]}, 8'h1);
    // R4: steady run, fetch every other cycle
    for (int i = 0; i < 8; i++) begin
      logic prev_f;
      prev_f = stage_en[0];
      step(1'b1, 1'b1, 1'b0);
      chk("R4", {7'b0, prev_f & stage_en[0]}, 8'h0);
    end
    // R9 / R11 directed: even-phase data request, odd-phase fetch request
    if (m_ph) step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic r;
      r = ($urandom % 5) != 0;
      step(r, 1'(($urandom)), 1'(($urandom)));
    end
    // R1: reset mid-run returns to even
    rst = 1'b1; @(posedge clk); @(negedge clk);
    chk("R1", {4'b0, stage_en}, 8'h0);
    rst = 1'b0; m_ph = 1'b0;
    step(1'b1, 1'b0, 1'b0);
    chk("R5", {7'b0, stage_en[0]}, 8'h1);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule